// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit with Greater-or-Equal Flags

This block is a 32-bit packed arithmetic stage that splits its word operands into two halfword lanes or four byte lanes and runs the lanes in parallel with no carry passing between them. It supports lane-wise add and subtract, and two cross-halfword forms that pair each half of the first operand with the opposite half of the second. It also provides an unsigned sum of absolute byte differences that is always added to a third operand, so a zero third operand gives the plain sum. A mode input selects signed or unsigned treatment of the lanes.

Each lane operation produces four greater-or-equal flags, one per byte position, and the block holds them in a register. A later byte-select operation reads that register to merge two words byte by byte. This makes compare-and-choose sequences possible without branches: a lane subtract marks which lanes of the first operand are at least as large, and the select then keeps the larger lanes. One operation is accepted per clock. Its result and flags appear one cycle later with an output strobe.

Top module: `simd_lane_alu`

## Requirements
- R1: While reset is asserted and right after it is released, `result` is zero, `ge_flags` is zero and `out_valid` is low.
- R2: An operation accepted with `in_valid` high at a clock edge gives its `result`, and its updated `ge_flags`, on the next edge, with `out_valid` high for exactly that cycle. Both outputs hold their values in cycles without `in_valid`.
- R3: Opcode 0 adds and opcode 1 subtracts (`src_a` minus `src_b`) the halfwords in bits [31:16] and [15:0] independently, each modulo 2^16, with no carry or borrow crossing bit 16.
- R4: Opcode 2 adds and opcode 3 subtracts the four byte lanes independently, each modulo 2^8. Lane i is bits [8i+7:8i].
- R5: Opcode 4 gives upper = a[31:16] + b[15:0] and lower = a[15:0] − b[31:16]. Opcode 5 gives upper = a[31:16] − b[15:0] and lower = a[15:0] + b[31:16].
- R6: Opcode 6 returns `src_c` plus the sum of the absolute differences of the four unsigned byte pairs of `src_a` and `src_b`, modulo 2^32. The signed mode has no effect on it.
- R7: With `signed_mode` = 0, the flag of an add lane is its carry-out and the flag of a subtract lane is set when no borrow occurs (a ≥ b).
- R8: With `signed_mode` = 1, a lane flag is set when the exact signed lane result, before wrapping, is zero or positive.
- R9: Byte-lane operations write flag bit i from byte lane i. Halfword operations (opcodes 0, 1, 4, 5) write the upper lane's flag into bits 3 and 2 and the lower lane's flag into bits 1 and 0.
- R10: Opcodes 6 and 7 leave `ge_flags` unchanged.
- R11: Opcode 7 forms result byte i from `src_a` when flag bit i, as held before this operation, is 1, and from `src_b` otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept an operation this cycle |
| op | input | 3 | Operation code 0 to 7 |
| signed_mode | input | 1 | 1 treats lanes as signed, 0 as unsigned |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| src_c | input | 32 | Accumulate operand of the absolute-difference sum |
| out_valid | output | 1 | Result of the previous accepted operation is present |
| result | output | 32 | Registered result |
| ge_flags | output | 4 | Held per-byte greater-or-equal flags |

## Verification
The bench builds the unit with its default lane width of 8 bits, so it is a 32-bit word with 16-bit halves. This keeps every lane small enough that carries, borrows and signed overflow at 0x7F/0x80 and 0xFFFF/0x0000 come up in directed vectors and in random ones. Flag-producing operations are followed directly by selects and by absolute-difference sums, so the bench sees both the flag handover between consecutive operations and the held flags. A reference model that tracks its own copy of the flags predicts each result in a scoreboard.

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
  parameter int LANE_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [2:0]             op,
  input  logic                   signed_mode,
  input  logic [4*LANE_BITS-1:0] src_a,
  input  logic [4*LANE_BITS-1:0] src_b,
  input  logic [4*LANE_BITS-1:0] src_c,
  output logic                   out_valid,
  output logic [4*LANE_BITS-1:0] result,
  output logic [3:0]             ge_flags
);

  localparam int LB = LANE_BITS;
  localparam int HW = 2 * LB;
  localparam int WW = 4 * LB;

  localparam logic [2:0] OP_ADD16 = 3'd0;
  localparam logic [2:0] OP_SUB16 = 3'd1;
  localparam logic [2:0] OP_ADD8  = 3'd2;
  localparam logic [2:0] OP_SUB8  = 3'd3;
  localparam logic [2:0] OP_XAS   = 3'd4;
  localparam logic [2:0] OP_XSA   = 3'd5;
  localparam logic [2:0] OP_SAD   = 3'd6;
  localparam logic [2:0] OP_SEL   = 3'd7;

  logic [WW-1:0] byte_res, half_res, sel_res, sad_acc;
  logic [3:0]    byte_ge;
  logic [1:0]    half_ge;
  logic [LB-1:0] absd [4];

  logic          exch;
  assign exch = (op == OP_XAS) || (op == OP_XSA);

  for (genvar i = 0; i < 4; i++) begin : g_byte
    logic [LB-1:0] x, y;
    logic [LB:0]   xe, ye, s;
    logic          sub;
    assign x   = src_a[i*LB +: LB];
    assign y   = src_b[i*LB +: LB];
    assign sub = (op == OP_SUB8);
    assign xe  = {signed_mode & x[LB-1], x};
    assign ye  = {signed_mode & y[LB-1], y};
    assign s   = sub ? (xe - ye) : (xe + ye);
    assign byte_res[i*LB +: LB] = s[LB-1:0];
    assign byte_ge[i] = (!signed_mode && !sub) ? s[LB] : ~s[LB];
    assign absd[i] = (x >= y) ? (x - y) : (y - x);
    assign sel_res[i*LB +: LB] = ge_flags[i] ? x : y;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HW-1:0] x, y;
    logic [HW:0]   xe, ye, s;
    logic          sub;
    assign x   = src_a[h*HW +: HW];
    assign y   = exch ? src_b[(1-h)*HW +: HW] : src_b[h*HW +: HW];
    assign sub = (op == OP_SUB16) || (op == ((h == 1) ? OP_XSA : OP_XAS));
    assign xe  = {signed_mode & x[HW-1], x};
    assign ye  = {signed_mode & y[HW-1], y};
    assign s   = sub ? (xe - ye) : (xe + ye);
    assign half_res[h*HW +: HW] = s[HW-1:0];
    assign half_ge[h] = (!signed_mode && !sub) ? s[HW] : ~s[HW];
  end

  always_comb begin
    sad_acc = src_c;
    for (int i = 0; i < 4; i++) sad_acc = sad_acc + WW'(absd[i]);
  end

  logic [WW-1:0] nxt_res;
  logic [3:0]    nxt_ge;

  always_comb begin
    nxt_ge = ge_flags;
    case (op)
      OP_ADD8, OP_SUB8: begin
        nxt_res = byte_res;
        nxt_ge  = byte_ge;
      end
      OP_SAD:  nxt_res = sad_acc;
      OP_SEL:  nxt_res = sel_res;
      default: begin
        nxt_res = half_res;
        nxt_ge  = {half_ge[1], half_ge[1], half_ge[0], half_ge[0]};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ge_flags  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= nxt_res;
        ge_flags <= nxt_ge;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(ge_flags)));
  a_r9_half_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_ADD16 || op == OP_SUB16 || exch)) |=>
      (ge_flags[3] == ge_flags[2] && ge_flags[1] == ge_flags[0]));
  a_r10_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_SAD || op == OP_SEL)) |=> $stable(ge_flags));

  for (genvar i = 0; i < 4; i++) begin : g_chk
    a_r11_select: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_SEL) |=>
        (result[i*LB +: LB] == ($past(ge_flags[i]) ? $past(src_a[i*LB +: LB])
                                                    : $past(src_b[i*LB +: LB]))));
  end

endmodule

// File: tb/simd_lane_alu_bench.sv
module simd_lane_alu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic        signed_mode = 1'b0;
  logic [31:0] src_a = '0, src_b = '0, src_c = '0;
  logic        out_valid;
  logic [31:0] result;
  logic [3:0]  ge_flags;

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_res_q [$];
  logic [3:0]  exp_flg_q [$];
  string       tag_q [$];
  logic [3:0]  mflags = '0;
  logic [31:0] last_res = '0;

  always #2.5 clk = ~clk;

  simd_lane_alu u_simd_lane_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .signed_mode(signed_mode), .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .out_valid(out_valid), .result(result), .ge_flags(ge_flags)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void lane(input longint x, input longint y, input int w, input bit sub,
                               input bit sm, output longint r, output bit f);
    longint m, xs, ys, t;
    m  = longint'(1) << w;
    xs = (sm && x >= m / 2) ? x - m : x;
    ys = (sm && y >= m / 2) ? y - m : y;
    t  = sub ? xs - ys : xs + ys;
    r  = ((t % m) + m) % m;
    f  = (sm || sub) ? (t >= 0) : (t >= m);
  endfunction

  function automatic logic [31:0] model(input logic [2:0] o, input bit sm,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] c);
    logic [31:0] res;
    longint r, s;
    bit f;
    res = '0;
    case (o)
      3'd0, 3'd1, 3'd4, 3'd5: begin
        lane(longint'(a[31:16]), longint'((o >= 3'd4) ? b[15:0] : b[31:16]), 16,
             (o == 3'd1) || (o == 3'd5), sm, r, f);
        res[31:16] = r[15:0]; mflags[3] = f; mflags[2] = f;
        lane(longint'(a[15:0]), longint'((o >= 3'd4) ? b[31:16] : b[15:0]), 16,
             (o == 3'd1) || (o == 3'd4), sm, r, f);
        res[15:0] = r[15:0]; mflags[1] = f; mflags[0] = f;
      end
      3'd2, 3'd3: begin
        for (int i = 0; i < 4; i++) begin
          lane(longint'(a[i*8 +: 8]), longint'(b[i*8 +: 8]), 8, o == 3'd3, sm, r, f);
          res[i*8 +: 8] = r[7:0];
          mflags[i] = f;
        end
      end
      3'd6: begin
        s = longint'(c);
        for (int i = 0; i < 4; i++) begin
          r = longint'(a[i*8 +: 8]) - longint'(b[i*8 +: 8]);
          s = s + ((r < 0) ? -r : r);
        end
        res = s[31:0];
      end
      default: begin
        for (int i = 0; i < 4; i++) res[i*8 +: 8] = mflags[i] ? a[i*8 +: 8] : b[i*8 +: 8];
      end
    endcase
    return res;
  endfunction

  task automatic send(input logic [2:0] o, input bit sm, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] c, input string tag);
    logic [31:0] e;
    e = model(o, sm, a, b, c);
    exp_res_q.push_back(e);
    exp_flg_q.push_back(mflags);
    tag_q.push_back(tag);
    last_res = e;
    op = o; signed_mode = sm; src_a = a; src_b = b; src_c = c; in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    src_a = 32'hDEAD_BEEF; src_b = 32'h1234_5678; op = 3'd2;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_res_q.size() == 0) begin
        check(1'b0, "R2 unexpected out_valid", {31'd0, out_valid}, 32'd0);
      end else begin
        logic [31:0] er;
        logic [3:0]  ef;
        string t;
        er = exp_res_q.pop_front();
        ef = exp_flg_q.pop_front();
        t  = tag_q.pop_front();
        check(result == er, {t, " result"}, result, er);
        check(ge_flags == ef, {t, " flags"}, {28'd0, ge_flags}, {28'd0, ef});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R2 watchdog expired", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(result == 32'd0, "R1 reset result", result, 32'd0);
    check(ge_flags == 4'd0, "R1 reset flags", {28'd0, ge_flags}, 32'd0);
    check(out_valid == 1'b0, "R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(result == 32'd0 && out_valid == 1'b0, "R1 after release", result, 32'd0);

    // R3 halfword add/sub, R7 unsigned flags
    send(3'd0, 0, 32'h0001_FFFF, 32'h0001_0001, 0, "R3 R7 add16 carry lo");
    send(3'd1, 0, 32'h0000_0005, 32'h0001_0003, 0, "R3 R7 sub16 borrow hi");
    send(3'd0, 1, 32'h7FFF_8000, 32'h0001_FFFF, 0, "R3 R8 add16 signed");
    send(3'd1, 1, 32'h8000_0001, 32'h0001_0001, 0, "R3 R8 sub16 signed");
    // R4 byte lanes, R9 byte flags
    send(3'd2, 0, 32'hFF80_0102, 32'h0180_FF01, 0, "R4 R9 add8 unsigned");
    send(3'd3, 0, 32'h1000_FF05, 32'h2000_0105, 0, "R4 R7 sub8 unsigned");
    send(3'd2, 1, 32'h7F80_01FF, 32'h0180_FF01, 0, "R4 R8 add8 signed");
    send(3'd3, 1, 32'h807F_0010, 32'h0180_0020, 0, "R4 R8 sub8 signed");
    // R11 select right after a flag producer
    send(3'd7, 0, 32'hAABB_CCDD, 32'h1122_3344, 0, "R11 select");
    // R5 exchange forms
    send(3'd4, 0, 32'h0010_0010, 32'h0020_0005, 0, "R5 xas unsigned");
    send(3'd5, 0, 32'h0010_0010, 32'h0020_0005, 0, "R5 xsa unsigned");
    send(3'd4, 1, 32'h8000_7FFF, 32'h0001_FFFF, 0, "R5 R8 xas signed");
    send(3'd5, 1, 32'h8000_7FFF, 32'h0001_FFFF, 0, "R5 R8 xsa signed");
    // R6 SAD and R10 flag retention
    send(3'd6, 0, 32'h00FF_1080, 32'hFF00_2080, 32'd0, "R6 R10 sad");
    send(3'd6, 1, 32'h0102_0304, 32'h0403_0201, 32'hFFFF_FFFE, "R6 R10 sad acc wrap");
    send(3'd7, 1, 32'h0102_0304, 32'hF0F1_F2F3, 0, "R10 R11 select after sad");
    send(3'd7, 0, 32'h5555_5555, 32'hAAAA_AAAA, 0, "R10 R11 select twice");
    idle(2);
    // R2 hold while idle
    check(out_valid == 1'b0, "R2 idle out_valid", {31'd0, out_valid}, 32'd0);
    check(result == last_res, "R2 idle hold result", result, last_res);
    check(ge_flags == mflags, "R2 idle hold flags", {28'd0, ge_flags}, {28'd0, mflags});

    for (int k = 0; k < 400; k++) begin
      send(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), $urandom, $urandom, $urandom,
           "R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
      if (k % 7 == 3) idle(1);
    end
    idle(3);
    check(exp_res_q.size() == 0, "R2 all results delivered", exp_res_q.size(), 32'd0);
    check(result == last_res, "R2 final hold", result, last_res);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule